// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte-Lane Aligner

This block sits between a processor's load/store path and a memory built from naturally aligned 64-bit elements. For each request it works out which byte lanes the access covers. The inputs are the physical byte address, a length code equal to the byte count minus one, the byte-order mode and whether the access is an instruction fetch.

A store moves right-justified data up into those lanes, and only the covered bytes get byte enables. A load takes the element that memory returns, extracts the covered lanes and hands them back right-justified and zero-extended. A 16-byte access uses a pair of elements, with the upper half on separate data ports.

An access that would run past the end of its element, or that uses an undefined length code, is refused and flagged. A misaligned fetch is refused and flagged separately. In reverse-endian mode, a fetch has its low address bits flipped before the lanes are chosen.

Top module: `lane_aligner`

## Requirements
- R1: After reset, `rvalid_o`, `err_o` and `align_o` are low.
- R2: A little-endian load of length code L at element offset O returns, right-justified and zero-extended, the bytes in lanes O through O+L. The result appears on `rdata_o` with `rvalid_o` high in the cycle after the request.
- R3: A big-endian load of length code L at offset O returns the bytes in lanes 7-O-L through 7-O, right-justified, with the lowest of those lanes as the least significant result byte.
- R4: Three-, five-, six- and seven-byte accesses (codes 2, 4, 5, 6) are legal and follow the same lane rules whenever offset plus code stays at or below 7.
- R5: A store writes the low L+1 bytes of `wdata_i` into the lanes that a load with the same address, code and byte order would read. The byte enables form a contiguous run of L+1 ones, and no other byte of the element changes.
- R6: The access is refused when offset plus code exceeds 7, or when the code is in the range 8 to 14. `err_o` then goes high for the cycle after the request, no memory request is issued, no memory byte changes and `rvalid_o` stays low.
- R7: Code 15 is a 16-byte access. It is legal only when address bits [3:0] are zero, and then moves `wdata_i`/`rdata_o` at the addressed element and `wdata_hi_i`/`rdata_hi_o` at the next element. Any other alignment is refused as in R6.
- R8: A fetch (`fetch_i` high) whose address ANDed with the length code is nonzero is refused. `align_o` goes high for the cycle after the request, with no memory request, and `err_o` stays low even when the boundary rule would also fail.
- R9: When `rev_endian_i` is set, a fetch XORs the low three address bits with (7 XOR code) before choosing lanes. A data load ignores `rev_endian_i`.
- R10: `err_o` and `align_o` are single-cycle pulses: they fall in the next cycle unless a new faulting request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| store_i | input | 1 | 1 = store, 0 = load |
| fetch_i | input | 1 | Load is an instruction fetch |
| big_endian_i | input | 1 | 1 = big-endian lane order |
| rev_endian_i | input | 1 | Reverse-endian mode for fetches |
| addr_i | input | AW | Physical byte address |
| len_i | input | 4 | Length code (bytes minus one; 15 = 16 bytes) |
| wdata_i | input | 64 | Right-justified store data (low half for 16 bytes) |
| wdata_hi_i | input | 64 | Upper store half for 16-byte access |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_pair_o | output | 1 | Access also covers the next element |
| mem_addr_o | output | AW-3 | Element index |
| mem_be_o | output | 8 | Byte enables of the addressed element |
| mem_wdata_o | output | 64 | Lane-positioned write data |
| mem_wdata_hi_o | output | 64 | Write data for the next element |
| mem_rdata_i | input | 64 | Element read data, valid one cycle after request |
| mem_rdata_hi_i | input | 64 | Next element read data |
| rvalid_o | output | 1 | Load result valid |
| rdata_o | output | 64 | Right-justified load result (low half) |
| rdata_hi_o | output | 64 | Upper half of a 16-byte load |
| err_o | output | 1 | Boundary / illegal length pulse |
| align_o | output | 1 | Fetch alignment pulse |

## Verification
Loads run against one element whose bytes all differ, so a wrong lane or a wrong byte order shows up as a wrong byte value. Offsets 0 and 7 and lengths 1 and 8 test both ends of the lane run in each byte order. Stores carry junk above the length and land on a known background, which tells a correct enable run apart from one that spills into a neighbouring byte. Fetches are tried with and without reverse-endian mode on the same address, and a data load is tried with the mode set. Faults include a fetch that breaks both the alignment and the boundary rule, which shows which flag takes priority.

// File: rtl/lane_aligner_pkg.sv
package lane_aligner_pkg;
  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } byte_order_e;
endpackage

// File: rtl/lane_aligner_lanes.sv
module lane_aligner_lanes
  import lane_aligner_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NB   = 8,
  parameter int OFFW = $clog2(NB),
  parameter int LENW = OFFW + 1
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [LENW-1:0] len_i,
  input  logic            fetch_i,
  input  logic            rev_i,
  input  byte_order_e     order_i,
  output logic            quad_o,
  output logic            misal_o,
  output logic            over_o,
  output logic [OFFW-1:0] lane_o,
  output logic [NB-1:0]   be_o
);
  localparam logic [OFFW-1:0] MASK = OFFW'(NB - 1);
  localparam logic [LENW-1:0] QUAD = LENW'(2 * NB - 1);

  logic [OFFW-1:0] len_lo, flip, off;
  logic [LENW:0]   reach;
  logic            over;

  assign len_lo  = len_i[OFFW-1:0];
  assign quad_o  = (len_i == QUAD);
  assign misal_o = fetch_i && ((addr_i[LENW-1:0] & len_i) != '0);
  // reverse-endian fetch flips the low address bits
  assign flip    = (fetch_i && rev_i) ? (MASK ^ len_lo) : '0;
  assign off     = addr_i[OFFW-1:0] ^ flip;
  assign reach   = {2'b00, off} + {1'b0, len_i};

  always_comb begin
    if (quad_o) over = (addr_i[OFFW:0] != '0);
    else        over = (reach > {2'b00, MASK});
  end

  assign over_o = over && !misal_o;
  assign lane_o = (order_i == ORDER_BIG) ? (MASK - off - len_lo) : off;

  for (genvar b = 0; b < NB; b++) begin : g_be
    localparam logic [OFFW:0] BI = (OFFW + 1)'(b);
    assign be_o[b] = quad_o ||
                     (({1'b0, lane_o} <= BI) && (BI <= ({1'b0, lane_o} + {1'b0, len_lo})));
  end
endmodule

// File: rtl/lane_aligner_load.sv
module lane_aligner_load #(
  parameter int NB   = 8,
  parameter int DW   = NB * 8,
  parameter int OFFW = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            fault_i,
  input  logic            misal_i,
  input  logic            quad_i,
  input  logic [OFFW-1:0] lane_i,
  input  logic [OFFW-1:0] len_i,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic [DW-1:0]   mem_rdata_hi_i,
  output logic            rvalid_o,
  output logic [DW-1:0]   rdata_o,
  output logic [DW-1:0]   rdata_hi_o,
  output logic            err_o,
  output logic            align_o
);
  logic            quad_q;
  logic [OFFW-1:0] lane_q, len_q;
  logic [DW-1:0]   shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      align_o  <= 1'b0;
      quad_q   <= 1'b0;
      lane_q   <= '0;
      len_q    <= '0;
    end else begin
      rvalid_o <= take_i;
      err_o    <= fault_i;
      align_o  <= misal_i;
      if (take_i) begin
        quad_q <= quad_i;
        lane_q <= lane_i;
        len_q  <= len_i;
      end
    end
  end

  assign shifted = mem_rdata_i >> {lane_q, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_pick
    localparam logic [OFFW-1:0] BI = OFFW'(b);
    assign rdata_o[b*8 +: 8] = quad_q ? mem_rdata_i[b*8 +: 8] :
                               ((BI <= len_q) ? shifted[b*8 +: 8] : 8'h00);
  end

  assign rdata_hi_o = quad_q ? mem_rdata_hi_i : '0;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_o, align_o, rvalid_o})); // R8
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_aligner_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NB   = 8,
  parameter int DW   = NB * 8,
  parameter int OFFW = $clog2(NB),
  parameter int LENW = OFFW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               store_i,
  input  logic               fetch_i,
  input  logic               big_endian_i,
  input  logic               rev_endian_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [LENW-1:0]    len_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      wdata_hi_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_pair_o,
  output logic [AW-OFFW-1:0] mem_addr_o,
  output logic [NB-1:0]      mem_be_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic [DW-1:0]      mem_wdata_hi_o,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic [DW-1:0]      mem_rdata_hi_i,
  output logic               rvalid_o,
  output logic [DW-1:0]      rdata_o,
  output logic [DW-1:0]      rdata_hi_o,
  output logic               err_o,
  output logic               align_o
);
  logic            quad, misal, over, ok;
  logic [OFFW-1:0] lane;
  logic [NB-1:0]   be;

  lane_aligner_lanes #(.AW(AW), .NB(NB), .OFFW(OFFW), .LENW(LENW)) u_lanes (
    .addr_i (addr_i),
    .len_i  (len_i),
    .fetch_i(fetch_i),
    .rev_i  (rev_endian_i),
    .order_i(byte_order_e'(big_endian_i)),
    .quad_o (quad),
    .misal_o(misal),
    .over_o (over),
    .lane_o (lane),
    .be_o   (be)
  );

  assign ok             = !over && !misal;
  assign mem_req_o      = req_i && ok;
  assign mem_we_o       = mem_req_o && store_i;
  assign mem_pair_o     = mem_req_o && quad;
  assign mem_addr_o     = addr_i[AW-1:OFFW];
  assign mem_be_o       = be & {NB{mem_we_o}};
  assign mem_wdata_o    = quad ? wdata_i : (wdata_i << {lane, 3'b000});
  assign mem_wdata_hi_o = quad ? wdata_hi_i : '0;

  lane_aligner_load #(.NB(NB), .DW(DW), .OFFW(OFFW)) u_load (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (mem_req_o && !store_i),
    .fault_i       (req_i && over),
    .misal_i       (req_i && misal),
    .quad_i        (quad),
    .lane_i        (lane),
    .len_i         (len_i[OFFW-1:0]),
    .mem_rdata_i   (mem_rdata_i),
    .mem_rdata_hi_i(mem_rdata_hi_i),
    .rvalid_o      (rvalid_o),
    .rdata_o       (rdata_o),
    .rdata_hi_o    (rdata_hi_o),
    .err_o         (err_o),
    .align_o       (align_o)
  );

  AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !store_i)); // R2
  AST_BE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_pair_o) |-> ($countones(mem_be_o) == int'(len_i) + 1)); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(!mem_req_o)); // R6
  AST_QUAD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_pair_o |-> (addr_i[OFFW:0] == '0)); // R7
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!err_o || $past(req_i))); // R10
endmodule

// File: tb/tb_lane_aligner.sv
module tb_lane_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NB = 8;
  localparam int DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, store = 0, fetch = 0, big = 0, rev = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    len = '0;
  logic [DW-1:0] wd = '0, wh = '0;
  logic mem_req, mem_we, mem_pair;
  logic [AW-4:0] mem_addr;
  logic [NB-1:0] mem_be;
  logic [DW-1:0] mem_wd, mem_wh, mem_rd = '0, mem_rh = '0;
  logic rvalid, err, align;
  logic [DW-1:0] rdata, rdata_hi;

  logic [DW-1:0] mem [16];
  int total = 0, bad = 0;
  logic [DW-1:0] s_rd, s_rh;
  logic s_rv, s_err, s_al;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_aligner dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .store_i(store), .fetch_i(fetch),
    .big_endian_i(big), .rev_endian_i(rev), .addr_i(addr), .len_i(len),
    .wdata_i(wd), .wdata_hi_i(wh), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_pair_o(mem_pair), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wd), .mem_wdata_hi_o(mem_wh), .mem_rdata_i(mem_rd),
    .mem_rdata_hi_i(mem_rh), .rvalid_o(rvalid), .rdata_o(rdata),
    .rdata_hi_o(rdata_hi), .err_o(err), .align_o(align)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < NB; b++)
          if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wd[b*8 +: 8];
        if (mem_pair) mem[mem_addr[3:0] + 4'd1] <= mem_wh;
      end else begin
        mem_rd <= mem[mem_addr[3:0]];
        mem_rh <= mem_pair ? mem[mem_addr[3:0] + 4'd1] : '0;
      end
    end
  end

  task automatic check(input string rq, input string what, input logic [DW-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(logic [DW-1:0] e, int off, int l, bit be);
    logic [DW-1:0] r = '0;
    for (int i = 0; i <= l; i++) begin
      int ln = be ? (7 - off - l + i) : (off + i);
      r[i*8 +: 8] = e[ln*8 +: 8];
    end
    return r;
  endfunction

  task automatic issue(input logic [AW-1:0] a, input logic [3:0] l, input logic st, fe, be, rv,
                       input logic [DW-1:0] d, dh);
    @(negedge clk);
    req = 1; addr = a; len = l; store = st; fetch = fe; big = be; rev = rv; wd = d; wh = dh;
    @(posedge clk);
    @(negedge clk);
    s_rd = rdata; s_rh = rdata_hi; s_rv = rvalid; s_err = err; s_al = align;
    req = 0; store = 0; fetch = 0; rev = 0;
  endtask

  task automatic load_chk(input string rq, input logic [AW-1:0] a, input int l, input bit be,
                          input logic [DW-1:0] exp);
    issue(a, 4'(l), 0, 0, be, 0, '0, '0);
    check(rq, $sformatf("load a=%h l=%0d be=%0d valid", a, l, be), 64'(s_rv), 64'd1);
    check(rq, $sformatf("load a=%h l=%0d be=%0d data", a, l, be), s_rd, exp);
  endtask

  localparam logic [DW-1:0] PAT = 64'h8877665544332211;

  task automatic t_reset;
    check("R1", "rvalid after reset", 64'(rvalid), 64'd0);
    check("R1", "err after reset", 64'(err), 64'd0);
    check("R1", "align after reset", 64'(align), 64'd0);
  endtask

  task automatic t_le_load;
    mem[2] = PAT;
    load_chk("R2", 32'h17, 0, 0, 64'h88);
    load_chk("R2", 32'h10, 7, 0, PAT);
    load_chk("R2", 32'h12, 1, 0, 64'h4433);
    load_chk("R2", 32'h14, 3, 0, pick(PAT, 4, 3, 0));
  endtask

  task automatic t_be_load;
    load_chk("R3", 32'h10, 0, 1, 64'h88);
    load_chk("R3", 32'h10, 3, 1, 64'h88776655);
    load_chk("R3", 32'h16, 1, 1, 64'h2211);
    load_chk("R3", 32'h10, 7, 1, PAT);
  endtask

  task automatic t_odd_len;
    load_chk("R4", 32'h15, 2, 0, 64'h887766);
    load_chk("R4", 32'h11, 4, 0, 64'h6655443322);
    load_chk("R4", 32'h11, 5, 1, pick(PAT, 1, 5, 1));
    load_chk("R4", 32'h10, 6, 1, 64'h88776655443322);
  endtask

  task automatic t_store;
    @(negedge clk); mem[6] = '0;
    issue(32'h32, 4'd1, 1, 0, 0, 0, 64'hDEADBEEF0000ABCD, '0);
    check("R5", "LE store halfword", mem[6], 64'h00000000ABCD0000);
    issue(32'h31, 4'd2, 1, 0, 1, 0, 64'hFFFFFFFFFF112233, '0);
    check("R5", "BE store 3 bytes", mem[6], 64'h00112233ABCD0000);
    issue(32'h30, 4'd4, 1, 0, 0, 0, 64'hFFFFFF0102030405, '0);
    check("R5", "LE store 5 bytes (R4)", mem[6], 64'h0011220102030405);
  endtask

  task automatic t_boundary;
    @(negedge clk); mem[3] = 64'hA5A5A5A5A5A5A5A5;
    issue(32'h1E, 4'd2, 1, 0, 0, 0, '1, '0);
    check("R6", "store over edge err", 64'(s_err), 64'd1);
    check("R6", "store over edge memory", mem[3], 64'hA5A5A5A5A5A5A5A5);
    issue(32'h15, 4'd3, 0, 0, 1, 0, '0, '0);
    check("R6", "load over edge err", 64'(s_err), 64'd1);
    check("R6", "load over edge no valid", 64'(s_rv), 64'd0);
    issue(32'h18, 4'd9, 1, 0, 0, 0, '1, '0);
    check("R6", "code 9 err", 64'(s_err), 64'd1);
    check("R6", "code 9 memory", mem[3], 64'hA5A5A5A5A5A5A5A5);
    @(negedge clk);
    check("R10", "err falls next cycle", 64'(err), 64'd0);
  endtask

  task automatic t_quad;
    issue(32'h20, 4'd15, 1, 0, 0, 0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
    check("R7", "quad store low", mem[4], 64'h0123456789ABCDEF);
    check("R7", "quad store high", mem[5], 64'hFEDCBA9876543210);
    issue(32'h20, 4'd15, 0, 0, 0, 0, '0, '0);
    check("R7", "quad load low", s_rd, 64'h0123456789ABCDEF);
    check("R7", "quad load high", s_rh, 64'hFEDCBA9876543210);
    issue(32'h28, 4'd15, 0, 0, 0, 0, '0, '0);
    check("R7", "quad odd element err", 64'(s_err), 64'd1);
    issue(32'h24, 4'd15, 1, 0, 0, 0, '1, '1);
    check("R7", "quad offset err", 64'(s_err), 64'd1);
    check("R7", "quad offset memory", mem[5], 64'hFEDCBA9876543210);
  endtask

  task automatic t_fetch_align;
    @(negedge clk); mem[1] = 64'h1122334455667788;
    issue(32'h0A, 4'd3, 0, 1, 0, 0, '0, '0);
    check("R8", "word fetch misaligned", 64'(s_al), 64'd1);
    check("R8", "word fetch no valid", 64'(s_rv), 64'd0);
    issue(32'h0E, 4'd3, 0, 1, 0, 0, '0, '0);
    check("R8", "align wins align", 64'(s_al), 64'd1);
    check("R8", "align wins no err", 64'(s_err), 64'd0);
    issue(32'h09, 4'd1, 0, 1, 0, 0, '0, '0);
    check("R8", "half fetch misaligned", 64'(s_al), 64'd1);
    @(negedge clk);
    check("R10", "align falls next cycle", 64'(align), 64'd0);
    issue(32'h0C, 4'd1, 0, 1, 0, 0, '0, '0);
    check("R8", "aligned half fetch", s_rd, 64'h3344);
  endtask

  task automatic t_rev_fetch;
    issue(32'h08, 4'd3, 0, 1, 0, 0, '0, '0);
    check("R9", "LE fetch word no rev", s_rd, 64'h55667788);
    issue(32'h08, 4'd3, 0, 1, 0, 1, '0, '0);
    check("R9", "LE fetch word rev", s_rd, 64'h11223344);
    issue(32'h0A, 4'd1, 0, 1, 0, 1, '0, '0);
    check("R9", "LE fetch half rev", s_rd, 64'h3344);
    issue(32'h08, 4'd3, 0, 1, 1, 1, '0, '0);
    check("R9", "BE fetch word rev", s_rd, 64'h55667788);
    issue(32'h08, 4'd3, 0, 0, 0, 1, '0, '0);
    check("R9", "data load ignores rev", s_rd, 64'h55667788);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_le_load();
    t_be_load();
    t_odd_len();
    t_store();
    t_boundary();
    t_quad();
    t_fetch_align();
    t_rev_fetch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule